// File: doc/BRIEF.md
# Zerotree Symbol Assignment Engine

This block takes one quantized wavelet tree of AC coefficients and labels every node with a zerotree symbol. A node can be marked as a zero root, an isolated zero, a value, a value root, or a descendant of a root. The coefficients are loaded through a write port into a tree buffer. In that buffer the root sits at index 0, and the children of node `i` sit at `4*i+1` through `4*i+4`. A start pulse begins the work. The engine then makes one pass over the buffer from the highest index down to the root and classifies each node.

Two per-node flag registers carry information between the passes. The first flag records that some node below is non-zero, and it is set at the parent of the node being classified. The second flag marks the node as a descendant of a zero root. The mark is set on the four children at once, when their parent turns out to be a ZTR or a VZTR. Neither flag needs a write back into the buffer.

Once the pass is complete, the engine streams the symbols out in ascending index order over a valid/ready port. Each symbol leaves together with its node index. The descendant mark moves down to the grandchildren as the stream goes on. When the last symbol has been taken, a one-cycle done pulse follows, and the engine is ready for the next tree.

Top module: `zt_symbol_engine`

## Requirements
- R1: `out_sym` encodes the symbols as 3-bit codes: ZTR=0, IZ=1, VAL=2, VZTR=3 and root-descendant (ZDESC)=4. No other code ever appears while `out_valid` is high.
- R2: A leaf node (index at or above the first leaf index, 5 for the default three levels) that has no ZTR or VZTR ancestor is ZTR when its coefficient is zero and VZTR when it is non-zero. The sign of the coefficient does not matter.
- R3: An internal node with at least one non-zero coefficient anywhere below it, and no ZTR or VZTR ancestor, is IZ when its own coefficient is zero and VAL when it is non-zero.
- R4: An internal node whose whole subtree below it is zero, and which has no ZTR or VZTR ancestor, is ZTR when its own coefficient is zero and VZTR when it is non-zero.
- R5: Every node that has an ancestor marked ZTR or VZTR is output as ZDESC (4), whatever its own value. The root is never ZDESC.
- R6: Each run outputs every index from 0 to NODES-1 exactly once, in ascending order, on `out_idx`.
- R7: While `out_valid` is high and `out_ready` is low, `out_valid`, `out_sym` and `out_idx` hold their values. No symbol is dropped or repeated.
- R8: After reset, `busy`, `out_valid` and `done` are low. Once a start is sampled in idle, `busy` is high from the next cycle. The first `out_valid` appears NODES cycles after the edge that sampled start.
- R9: The cycle after the handshake of the last index, `done` is high for exactly one cycle and `busy` is low.
- R10: While `busy` is high, `wr_en` and `start` are ignored. A later run without a reload produces the symbols of the tree loaded before the run.
- R11: Every start clears both flag sets, so the result of a run does not depend on earlier runs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Write one coefficient into the tree buffer (idle only) |
| wr_idx | input | IDX_W | Node index of the write |
| wr_coef | input | COEF_W | Quantized coefficient, two's complement |
| start | input | 1 | Begin assignment of the loaded tree |
| busy | output | 1 | Run in progress |
| done | output | 1 | One-cycle pulse after the last symbol is accepted |
| out_valid | output | 1 | Symbol available |
| out_ready | input | 1 | Consumer accepts the symbol |
| out_sym | output | 3 | Symbol code (see R1) |
| out_idx | output | IDX_W | Node index of the symbol |

## Verification
The hardest case to reach is a ZDESC mark that has to travel two levels down. This needs a zero-subtree root at an internal node, and its grandchildren must then come out as ZDESC even though they hold non-zero values. Test trees place non-zero leaves under ZTR and VZTR parents, and also a single non-zero deepest leaf, so that each flag path is used on its own. Back-pressure comes from alternating and pseudo-random ready patterns. Writes and start pulses are injected during a run, and the same tree is then run again without a reload.

// File: rtl/zt_pkg.sv
package zt_pkg;

  typedef enum logic [2:0] {
    SYM_ZTR   = 3'd0,
    SYM_IZ    = 3'd1,
    SYM_VAL   = 3'd2,
    SYM_VZTR  = 3'd3,
    SYM_ZDESC = 3'd4
  } zsym_e;

  // Node count of a full 4-ary tree with lv levels.
  function automatic int tree_nodes(input int lv);
    int n;
    int p;
    n = 0;
    p = 1;
    for (int i = 0; i < lv; i++) begin
      n += p;
      p *= 4;
    end
    return n;
  endfunction

  // Index of the first leaf (nodes of all levels above the last).
  function automatic int first_leaf(input int lv);
    return tree_nodes(lv - 1);
  endfunction

  function automatic int child_base(input int i);
    return 4 * i + 1;
  endfunction

  function automatic int parent_of(input int c);
    return (c - 1) / 4;
  endfunction

  // sig: own coefficient non-zero; below_nz: something non-zero beneath.
  function automatic zsym_e classify(input logic sig, input logic below_nz);
    zsym_e s;
    if (below_nz) s = sig ? SYM_VAL : SYM_IZ;
    else          s = sig ? SYM_VZTR : SYM_ZTR;
    return s;
  endfunction

  function automatic logic is_root_kind(input zsym_e s);
    return (s == SYM_ZTR) || (s == SYM_VZTR);
  endfunction

endpackage

// File: rtl/zt_tree_store.sv
module zt_tree_store #(
  parameter int NODES  = 21,
  parameter int IDX_W  = 5,
  parameter int COEF_W = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              coef_we,
  input  logic [IDX_W-1:0]  coef_widx,
  input  logic [COEF_W-1:0] coef_wdata,
  input  logic [IDX_W-1:0]  coef_ridx,
  output logic              coef_nz,
  input  logic              sym_we,
  input  logic [IDX_W-1:0]  sym_widx,
  input  zt_pkg::zsym_e     sym_wdata,
  input  logic [IDX_W-1:0]  sym_ridx,
  output zt_pkg::zsym_e     sym_rdata
);

  logic [COEF_W-1:0] coef_mem [NODES];
  zt_pkg::zsym_e     sym_mem  [NODES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int k = 0; k < NODES; k++) coef_mem[k] <= '0;
    end else if (coef_we && (int'(coef_widx) < NODES)) begin
      coef_mem[coef_widx] <= coef_wdata;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int k = 0; k < NODES; k++) sym_mem[k] <= zt_pkg::SYM_ZTR;
    end else if (sym_we) begin
      sym_mem[sym_widx] <= sym_wdata;
    end
  end

  assign coef_nz   = (int'(coef_ridx) < NODES) ? (coef_mem[coef_ridx] != '0) : 1'b0;
  assign sym_rdata = (int'(sym_ridx) < NODES) ? sym_mem[sym_ridx] : zt_pkg::SYM_ZTR;

endmodule

// File: rtl/zt_flag_bank.sv
module zt_flag_bank #(
  parameter int NODES = 21,
  parameter int IDX_W = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clear,
  input  logic             below_set,
  input  logic [IDX_W-1:0] below_idx,
  input  logic             mark_en,
  input  logic [IDX_W-1:0] mark_base,
  input  logic [IDX_W-1:0] rd_idx,
  output logic             rd_below,
  output logic             rd_mark
);

  logic [NODES-1:0] below_q;
  logic [NODES-1:0] mark_q;

  generate
    for (genvar k = 0; k < NODES; k++) begin : g_node
      logic hit_below;
      logic hit_mark;
      assign hit_below = below_set && (int'(below_idx) == k);
      assign hit_mark  = mark_en && (k >= int'(mark_base)) && (k < int'(mark_base) + 4);

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          below_q[k] <= 1'b0;
          mark_q[k]  <= 1'b0;
        end else if (clear) begin
          below_q[k] <= 1'b0;
          mark_q[k]  <= 1'b0;
        end else begin
          if (hit_below) below_q[k] <= 1'b1;
          if (hit_mark)  mark_q[k]  <= 1'b1;
        end
      end
    end
  endgenerate

  assign rd_below = (int'(rd_idx) < NODES) ? below_q[rd_idx] : 1'b0;
  assign rd_mark  = (int'(rd_idx) < NODES) ? mark_q[rd_idx]  : 1'b0;

endmodule

// File: rtl/zt_sequencer.sv
module zt_sequencer #(
  parameter int NODES = 21,
  parameter int IDX_W = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic             out_ready,
  output logic             busy,
  output logic             asg_active,
  output logic             gen_active,
  output logic [IDX_W-1:0] idx,
  output logic             start_fire,
  output logic             gen_fire,
  output logic             last_fire,
  output logic             done
);

  typedef enum logic [1:0] {ST_IDLE, ST_ASSIGN, ST_GEN} st_e;

  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(NODES - 1);

  st_e state_q;
  logic [IDX_W-1:0] idx_q;
  logic done_q;

  assign asg_active = (state_q == ST_ASSIGN);
  assign gen_active = (state_q == ST_GEN);
  assign busy       = (state_q != ST_IDLE);
  assign start_fire = (state_q == ST_IDLE) && start;
  assign gen_fire   = gen_active && out_ready;
  assign last_fire  = gen_fire && (idx_q == LAST_IDX);
  assign idx        = idx_q;
  assign done       = done_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      idx_q   <= '0;
      done_q  <= 1'b0;
    end else begin
      done_q <= 1'b0;
      unique case (state_q)
        ST_IDLE: begin
          if (start) begin
            state_q <= ST_ASSIGN;
            idx_q   <= LAST_IDX;
          end
        end
        ST_ASSIGN: begin
          if (idx_q == '0) state_q <= ST_GEN;
          else             idx_q   <= idx_q - 1'b1;
        end
        ST_GEN: begin
          if (gen_fire) begin
            if (idx_q == LAST_IDX) begin
              state_q <= ST_IDLE;
              idx_q   <= '0;
              done_q  <= 1'b1;
            end else begin
              idx_q <= idx_q + 1'b1;
            end
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/zt_symbol_engine.sv
module zt_symbol_engine #(
  parameter int LEVELS = 3,
  parameter int COEF_W = 12,
  localparam int NODES = zt_pkg::tree_nodes(LEVELS),
  localparam int IDX_W = $clog2(NODES)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [IDX_W-1:0]  wr_idx,
  input  logic [COEF_W-1:0] wr_coef,
  input  logic              start,
  output logic              busy,
  output logic              done,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [2:0]        out_sym,
  output logic [IDX_W-1:0]  out_idx
);

  localparam int LEAF0 = zt_pkg::first_leaf(LEVELS);

  logic             asg_active;
  logic             gen_active;
  logic [IDX_W-1:0] idx;
  logic             start_fire;
  logic             gen_fire;
  logic             last_fire;
  logic             asg_fire;

  logic             cur_nz;
  logic             cur_below;
  logic             cur_mark;
  logic             cur_leaf;
  zt_pkg::zsym_e    cur_cls;
  zt_pkg::zsym_e    stored_sym;

  logic             below_set;
  logic [IDX_W-1:0] parent_idx;
  logic             asg_mark;
  logic             gen_mark;
  logic             mark_en;
  logic [IDX_W-1:0] child0_idx;

  zt_sequencer #(.NODES(NODES), .IDX_W(IDX_W)) seq_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .start      (start),
    .out_ready  (out_ready),
    .busy       (busy),
    .asg_active (asg_active),
    .gen_active (gen_active),
    .idx        (idx),
    .start_fire (start_fire),
    .gen_fire   (gen_fire),
    .last_fire  (last_fire),
    .done       (done)
  );

  assign asg_fire   = asg_active;
  assign cur_leaf   = (int'(idx) >= LEAF0);
  assign cur_cls    = zt_pkg::classify(cur_nz, cur_below);
  assign parent_idx = IDX_W'(zt_pkg::parent_of(int'(idx)));
  assign child0_idx = cur_leaf ? '0 : IDX_W'(zt_pkg::child_base(int'(idx)));

  assign below_set  = asg_fire && (idx != '0) && (cur_nz || cur_below);
  assign asg_mark   = asg_fire && !cur_leaf && zt_pkg::is_root_kind(cur_cls);
  assign gen_mark   = gen_fire && !cur_leaf && cur_mark;
  assign mark_en    = asg_mark || gen_mark;

  zt_tree_store #(.NODES(NODES), .IDX_W(IDX_W), .COEF_W(COEF_W)) store_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .coef_we    (wr_en && !busy),
    .coef_widx  (wr_idx),
    .coef_wdata (wr_coef),
    .coef_ridx  (idx),
    .coef_nz    (cur_nz),
    .sym_we     (asg_fire),
    .sym_widx   (idx),
    .sym_wdata  (cur_cls),
    .sym_ridx   (idx),
    .sym_rdata  (stored_sym)
  );

  zt_flag_bank #(.NODES(NODES), .IDX_W(IDX_W)) flags_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .clear     (start_fire),
    .below_set (below_set),
    .below_idx (parent_idx),
    .mark_en   (mark_en),
    .mark_base (child0_idx),
    .rd_idx    (idx),
    .rd_below  (cur_below),
    .rd_mark   (cur_mark)
  );

  assign out_valid = gen_active;
  assign out_idx   = idx;
  assign out_sym   = cur_mark ? zt_pkg::SYM_ZDESC : stored_sym;

endmodule

// File: rtl/zt_symbol_engine_chk.sv
module zt_symbol_engine_chk #(
  parameter int NODES = 21,
  parameter int IDX_W = 5
) (
  input logic             clk,
  input logic             rst_n,
  input logic             busy,
  input logic             done,
  input logic             out_valid,
  input logic             out_ready,
  input logic [2:0]       out_sym,
  input logic [IDX_W-1:0] out_idx,
  input logic             last_fire,
  input logic             start_fire
);

  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(NODES - 1);

  AST_SYM_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (out_sym <= 3'd4)); // R1

  AST_ROOT_NOT_DESC: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_idx == '0) |-> (out_sym != 3'd4)); // R5

  AST_IDX_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_ready && out_idx != LAST_IDX) |=> (out_valid && out_idx == $past(out_idx) + 1'b1)); // R6

  AST_HOLD_STALL: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_sym) && $stable(out_idx))); // R7

  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !out_valid); // R8

  AST_START_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    start_fire |=> (busy && !out_valid)); // R8

  AST_DONE_AFTER_LAST: assert property (@(posedge clk) disable iff (!rst_n)
    last_fire |=> (done && !busy)); // R9

  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done); // R9

endmodule

bind zt_symbol_engine zt_symbol_engine_chk #(.NODES(NODES), .IDX_W(IDX_W)) chk_i (
  .clk        (clk),
  .rst_n      (rst_n),
  .busy       (busy),
  .done       (done),
  .out_valid  (out_valid),
  .out_ready  (out_ready),
  .out_sym    (out_sym),
  .out_idx    (out_idx),
  .last_fire  (last_fire),
  .start_fire (start_fire)
);

// File: tb/zt_symbol_engine_tb_top.sv
module zt_symbol_engine_tb_top;

  localparam int LEVELS = 3;
  localparam int COEF_W = 12;
  localparam int NODES  = 21;
  localparam int IDX_W  = 5;
  localparam int LEAF0  = 5;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              wr_en = 1'b0;
  logic [IDX_W-1:0]  wr_idx = '0;
  logic [COEF_W-1:0] wr_coef = '0;
  logic              start = 1'b0;
  logic              busy;
  logic              done;
  logic              out_valid;
  logic              out_ready = 1'b0;
  logic [2:0]        out_sym;
  logic [IDX_W-1:0]  out_idx;

  int checks = 0;
  int fails  = 0;
  int cyc    = 0;
  logic [15:0] lfsr = 16'hACE1;

  int tcoef   [NODES];
  int exp_sym [NODES];

  always #4 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  zt_symbol_engine #(.LEVELS(LEVELS), .COEF_W(COEF_W)) dut_i (
    .clk (clk), .rst_n (rst_n), .wr_en (wr_en), .wr_idx (wr_idx), .wr_coef (wr_coef),
    .start (start), .busy (busy), .done (done), .out_valid (out_valid),
    .out_ready (out_ready), .out_sym (out_sym), .out_idx (out_idx)
  );

  task automatic check(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  // Recomputed from the requirements: any non-zero strictly below node n.
  function automatic bit nz_below(input int n);
    bit r;
    r = 1'b0;
    for (int j = 1; j <= 4; j++) begin
      int c;
      c = 4 * n + j;
      if (c < NODES) r |= (tcoef[c] != 0) || nz_below(c);
    end
    return r;
  endfunction

  function automatic string req_of(input int n);
    if (exp_sym[n] == 4) return "R5";
    if (n >= LEAF0)      return "R2";
    if (exp_sym[n] == 1 || exp_sym[n] == 2) return "R3";
    return "R4";
  endfunction

  task automatic build_expect();
    int base [NODES];
    bit under [NODES];
    for (int n = 0; n < NODES; n++) begin
      bit own;
      bit blw;
      own = (tcoef[n] != 0);
      blw = nz_below(n);
      if (blw) base[n] = own ? 2 : 1;
      else     base[n] = own ? 3 : 0;
    end
    for (int n = 0; n < NODES; n++) begin
      if (n == 0) under[n] = 1'b0;
      else begin
        int p;
        p = (n - 1) / 4;
        under[n] = under[p] || (base[p] == 0) || (base[p] == 3);
      end
      exp_sym[n] = under[n] ? 4 : base[n];
    end
  endtask

  task automatic load_tree();
    for (int n = 0; n < NODES; n++) begin
      @(negedge clk);
      wr_en   = 1'b1;
      wr_idx  = IDX_W'(n);
      wr_coef = COEF_W'(tcoef[n]);
    end
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  // mode 0: always ready, 1: alternate, 2: pseudo-random. inject: poke during run (R10).
  task automatic run_tree(input string name, input int mode, input bit inject);
    int n;
    int next_idx;
    int held_sym;
    int held_idx;
    bit was_stall;
    build_expect();
    @(negedge clk);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    check("R8", {name, " busy after start"}, int'(busy), 1);
    n = 0;
    while (!out_valid && n < 1000) begin
      if (inject && n == 3) begin
        wr_en = 1'b1; wr_idx = '0; wr_coef = 12'h7FF; start = 1'b1;
      end else begin
        wr_en = 1'b0; start = 1'b0;
      end
      @(negedge clk);
      n++;
    end
    wr_en = 1'b0; start = 1'b0;
    check("R8", {name, " cycles to first symbol"}, n, NODES);
    next_idx  = 0;
    was_stall = 1'b0;
    held_sym  = 0;
    held_idx  = 0;
    while (next_idx < NODES && n < 2000) begin
      bit rdy;
      if (was_stall) begin
        check("R7", {name, " valid held"}, int'(out_valid), 1);
        check("R7", {name, " sym held"}, int'(out_sym), held_sym);
        check("R7", {name, " idx held"}, int'(out_idx), held_idx);
      end
      case (mode)
        0: rdy = 1'b1;
        1: rdy = cyc[0];
        default: begin
          lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
          rdy = lfsr[0];
        end
      endcase
      if (inject && next_idx == 7) begin
        wr_en = 1'b1; wr_idx = IDX_W'(9); wr_coef = 12'h123; start = 1'b1;
      end else begin
        wr_en = 1'b0; start = 1'b0;
      end
      out_ready = rdy;
      if (out_valid && rdy) begin
        check("R6", {name, " index order"}, int'(out_idx), next_idx);
        check(req_of(next_idx), $sformatf("%s sym of node %0d", name, next_idx),
              int'(out_sym), exp_sym[next_idx]);
        next_idx++;
        was_stall = 1'b0;
      end else if (out_valid) begin
        was_stall = 1'b1;
        held_sym  = int'(out_sym);
        held_idx  = int'(out_idx);
      end
      @(negedge clk);
      n++;
    end
    out_ready = 1'b0; wr_en = 1'b0; start = 1'b0;
    check("R9", {name, " done pulse"}, int'(done), 1);
    check("R9", {name, " busy low at done"}, int'(busy), 0);
    @(negedge clk);
    check("R9", {name, " done one cycle"}, int'(done), 0);
    check("R6", {name, " no extra symbol"}, int'(out_valid), 0);
  endtask

  task automatic t_reset();
    check("R8", "reset busy", int'(busy), 0);
    check("R8", "reset out_valid", int'(out_valid), 0);
    check("R9", "reset done", int'(done), 0);
  endtask

  task automatic t_all_zero();
    for (int n = 0; n < NODES; n++) tcoef[n] = 0;
    load_tree();
    run_tree("all-zero R4 R5", 0, 1'b0);
  endtask

  task automatic t_all_nonzero();
    for (int n = 0; n < NODES; n++) tcoef[n] = (n % 2 == 0) ? n + 1 : -(n + 1);
    load_tree();
    run_tree("all-nonzero R3 R2 R11", 1, 1'b0);
  endtask

  task automatic t_deep_leaf();
    for (int n = 0; n < NODES; n++) tcoef[n] = 0;
    tcoef[20] = -3;
    load_tree();
    run_tree("deep-leaf R3", 2, 1'b0);
  endtask

  task automatic t_root_only();
    for (int n = 0; n < NODES; n++) tcoef[n] = 0;
    tcoef[0] = 9;
    tcoef[13] = 5;
    tcoef[2]  = 0;
    load_tree();
    run_tree("root-kids R3 R5", 0, 1'b0);
    for (int n = 1; n < NODES; n++) tcoef[n] = 0;
    load_tree();
    run_tree("root-only R4 R5", 1, 1'b0);
  endtask

  task automatic t_mixed();
    for (int n = 0; n < NODES; n++) tcoef[n] = 0;
    tcoef[1] = 4;  tcoef[6] = 1;
    tcoef[2] = 2;
    tcoef[11] = -1;
    tcoef[4] = 0;  tcoef[17] = 8; tcoef[19] = 0;
    tcoef[3] = 7;  tcoef[14] = 6;
    tcoef[13] = 0;
    load_tree();
    run_tree("mixed R2 R3 R4 R5", 2, 1'b0);
  endtask

  task automatic t_ignore_busy();
    for (int n = 0; n < NODES; n++) tcoef[n] = 0;
    tcoef[5] = 3;
    tcoef[10] = 2;
    load_tree();
    run_tree("inject R10", 2, 1'b1);
    run_tree("rerun R10", 0, 1'b0);
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    fails++;
    checks++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin : main
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_all_zero();
    t_all_nonzero();
    t_deep_leaf();
    t_root_only();
    t_mixed();
    t_ignore_busy();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule